// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes a three-wire serial audio stream (bit clock, data line, left/right clock) into the system clock domain and turns it into pairs of parallel samples. All three wires are brought through a synchronizer and sampled by the system clock. Each rising edge of the bit clock captures one data bit. Each change of the left/right clock level closes the word that was being received. The word is read as right-justified: the last N bits before the level change are the sample. Any earlier bits in that half-frame are padding and are discarded.

Two configuration inputs select the word length (16 or 18 bits) and the bit order (MSB first or LSB first). A 16-bit word is sign-extended, so the outputs are always 18 bits wide. A word completed while the left/right clock was high is the left sample. A word completed while it was low is the right sample. When the left/right clock rises, the left word from the high half and the right word from the low half that just ended are published together, with a one-cycle valid strobe.

The serial source runs freely and cannot be stalled, so the output stream has no ready input. A consumer must take the pair in the cycle the strobe is high. The pair then stays on the outputs until the next strobe. The configuration inputs are read only at the moment a word closes, so they must be held steady from the start of a frame until the first bit of the following frame has been taken.

Top module: `srx_stereo_rx`

## Requirements
- R1: Data is captured on rising bit-clock edges. When the left/right level changes, the bits from the last N rising edges before the change form the word. Earlier bits in that half-frame have no effect on the output.
- R2: A word received while the left/right clock is high appears on left_o. A word received while it is low appears on right_o.
- R3: When cfg_long_i is 1 the word is 18 bits long. When it is 0 the word is 16 bits long.
- R4: A 16-bit word appears on the 18-bit outputs with bits 17 and 16 equal to bit 15.
- R5: pair_valid_o is high for exactly one system clock cycle for each rising edge of the left/right clock that closes a complete frame. No pair is produced at any other time.
- R6: left_o and right_o change only in the cycle in which pair_valid_o is high, and otherwise hold their values.
- R7: While rst_n is low, pair_valid_o is 0 and both sample outputs are 0.
- R8: When cfg_lsb_first_i is 1 the first of the N word bits is bit 0. When it is 0 the first is bit N-1.
- R9: After reset, the first bit-clock edge only records the left/right level. A pair is published only after a rising level change, a falling level change and a further rising level change have all been seen, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Left/right clock, high for the left half-frame |
| sdata_i | input | 1 | Serial audio data |
| cfg_long_i | input | 1 | 1 selects 18-bit words, 0 selects 16-bit words |
| cfg_lsb_first_i | input | 1 | 1 selects LSB first, 0 selects MSB first |
| pair_valid_o | output | 1 | One-cycle strobe marking a new sample pair |
| left_o | output | 18 | Left sample, two's complement |
| right_o | output | 18 | Right sample, two's complement |

## Verification
The assertions rely on three conditions on the inputs. Each bit-clock level lasts at least two system clocks, so consecutive rising edges are never detected in adjacent cycles. Data and left/right change only while the bit clock is low. The word-length input is stable at the edge that closes a right word. The stimulus meets these conditions by design: it holds every bit-clock phase for two system clocks, changes data and left/right together on the falling phase, and alters the configuration only after the first bit of a new frame has passed through the synchronizer. The padding bits it inserts ahead of each word are ones, so a receiver that captures them would show a visible error.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned DEF_LONG_W  = 18;
  localparam int unsigned DEF_SHORT_W = 16;

  // raw serial lines bundled for the synchronizer
  typedef struct packed {
    logic bclk;
    logic lrclk;
    logic sdata;
  } line_t;

  // progress towards a complete frame since reset
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_LEFT_OPEN = 2'd1,
    PH_LEFT_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srx_bit_capture.sv
module srx_bit_capture #(
  parameter int unsigned HIST_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              lr_s,
  input  logic              dat_s,
  output logic [HIST_W-1:0] hist_o,
  output logic              lr_up_o,
  output logic              lr_dn_o
);
  logic              bclk_q;
  logic              primed_q;
  logic              lr_last_q;
  logic [HIST_W-1:0] hist_q;
  logic              bit_rise;
  logic              lr_change;

  assign bit_rise  = bclk_s & ~bclk_q;
  assign lr_change = bit_rise & primed_q & (lr_s ^ lr_last_q);
  assign lr_up_o   = lr_change & lr_s;
  assign lr_dn_o   = lr_change & ~lr_s;
  assign hist_o    = hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      primed_q  <= 1'b0;
      lr_last_q <= 1'b0;
      hist_q    <= '0;
    end else begin
      bclk_q <= bclk_s;
      if (bit_rise) begin
        primed_q  <= 1'b1;
        lr_last_q <= lr_s;
        if (lr_change) begin
          hist_q <= HIST_W'(dat_s);
        end else begin
          hist_q <= {hist_q[HIST_W-2:0], dat_s};
        end
      end
    end
  end
endmodule

// File: rtl/srx_word_align.sv
module srx_word_align #(
  parameter int unsigned LONG_W  = 18,
  parameter int unsigned SHORT_W = 16
) (
  input  logic [LONG_W-1:0] hist_i,
  input  logic              cfg_long_i,
  input  logic              cfg_lsb_first_i,
  output logic [LONG_W-1:0] word_o
);
  localparam int unsigned EXT_W = LONG_W - SHORT_W;

  logic [LONG_W-1:0]  long_fwd, long_rev;
  logic [SHORT_W-1:0] short_fwd, short_rev, short_sel;

  for (genvar i = 0; i < LONG_W; i++) begin : g_long
    assign long_fwd[i] = hist_i[i];
    assign long_rev[i] = hist_i[LONG_W-1-i];
  end

  for (genvar i = 0; i < SHORT_W; i++) begin : g_short
    assign short_fwd[i] = hist_i[i];
    assign short_rev[i] = hist_i[SHORT_W-1-i];
  end

  assign short_sel = cfg_lsb_first_i ? short_rev : short_fwd;

  always_comb begin
    if (cfg_long_i) begin
      word_o = cfg_lsb_first_i ? long_rev : long_fwd;
    end else begin
      word_o = {{EXT_W{short_sel[SHORT_W-1]}}, short_sel};
    end
  end
endmodule

// File: rtl/srx_pair_out.sv
module srx_pair_out
  import srx_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  input  logic         lr_up_i,
  input  logic         lr_dn_i,
  output logic         valid_o,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o
);
  phase_e       phase_q;
  logic [W-1:0] hold_left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      hold_left_q <= '0;
      valid_o     <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
    end else begin
      valid_o <= 1'b0;
      if (lr_dn_i) begin
        hold_left_q <= word_i;
        if (phase_q == PH_LEFT_OPEN) phase_q <= PH_LEFT_DONE;
      end
      if (lr_up_i) begin
        if (phase_q == PH_LEFT_DONE) begin
          valid_o <= 1'b1;
          left_o  <= hold_left_q;
          right_o <= word_i;
        end
        phase_q <= PH_LEFT_OPEN;
      end
    end
  end
endmodule

// File: rtl/srx_stereo_rx.sv
module srx_stereo_rx
  import srx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LONG_W      = DEF_LONG_W,
  parameter int unsigned SHORT_W     = DEF_SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  input  logic              cfg_long_i,
  input  logic              cfg_lsb_first_i,
  output logic              pair_valid_o,
  output logic [LONG_W-1:0] left_o,
  output logic [LONG_W-1:0] right_o
);
  localparam int unsigned LINE_W = $bits(line_t);

  line_t             raw_l, syn_l;
  logic              lr_s;
  logic [LONG_W-1:0] hist;
  logic [LONG_W-1:0] word;
  logic              lr_up, lr_dn;

  assign raw_l = '{bclk: bclk_i, lrclk: lrclk_i, sdata: sdata_i};
  assign lr_s  = syn_l.lrclk;

  srx_sync #(.STAGES(SYNC_STAGES), .W(LINE_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_l),
    .q_o   (syn_l)
  );

  srx_bit_capture #(.HIST_W(LONG_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk_s  (syn_l.bclk),
    .lr_s    (lr_s),
    .dat_s   (syn_l.sdata),
    .hist_o  (hist),
    .lr_up_o (lr_up),
    .lr_dn_o (lr_dn)
  );

  srx_word_align #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_align (
    .hist_i          (hist),
    .cfg_long_i      (cfg_long_i),
    .cfg_lsb_first_i (cfg_lsb_first_i),
    .word_o          (word)
  );

  srx_pair_out #(.W(LONG_W)) u_pair (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_i  (word),
    .lr_up_i (lr_up),
    .lr_dn_i (lr_dn),
    .valid_o (pair_valid_o),
    .left_o  (left_o),
    .right_o (right_o)
  );
endmodule

// File: rtl/srx_stereo_rx_chk.sv
module srx_stereo_rx_chk #(
  parameter int unsigned W  = 18,
  parameter int unsigned SW = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_long_i,
  input logic         lr_s,
  input logic         pair_valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o
);
  a_r7_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!pair_valid_o && left_o == '0 && right_o == '0));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o |=> !pair_valid_o);

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r2_publish_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o |-> $past(lr_s));

  a_r4_short_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid_o && !$past(cfg_long_i)) |->
      ((&right_o[W-1:SW-1]) || !(|right_o[W-1:SW-1])));
endmodule

bind srx_stereo_rx srx_stereo_rx_chk #(.W(LONG_W), .SW(SHORT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_long_i   (cfg_long_i),
  .lr_s         (lr_s),
  .pair_valid_o (pair_valid_o),
  .left_o       (left_o),
  .right_o      (right_o)
);

// File: tb/tb_srx_stereo_rx.sv
`timescale 1ns/1ps
module tb_srx_stereo_rx;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b1, sdata = 1'b0;
  logic        cfg_long = 1'b1, cfg_lsb = 1'b0;
  logic        pair_valid;
  logic [17:0] left, right;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  srx_stereo_rx #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .cfg_long_i(cfg_long), .cfg_lsb_first_i(cfg_lsb),
    .pair_valid_o(pair_valid), .left_o(left), .right_o(right)
  );

  // ---------------- reference model, evaluated at every clock ----------------
  logic [2:0]  smp [SYNC+2];
  int          m_hist, m_phase;
  bit          m_primed, m_lr_last, m_valid;
  logic [17:0] m_hold, m_left, m_right;

  function automatic logic [17:0] ref_word(int h, bit lng, bit lsb);
    int n;
    logic [17:0] w;
    n = lng ? 18 : 16;
    w = '0;
    for (int i = 0; i < n; i++) w[i] = lsb ? h[n-1-i] : h[i];
    if (!lng) begin w[16] = w[15]; w[17] = w[15]; end
    return w;
  endfunction

  always @(posedge clk) begin
    logic b, bq, lr, d;
    logic [17:0] w;
    if (!rst_n) begin
      for (int i = 0; i < SYNC+2; i++) smp[i] = '0;
      m_hist = 0; m_phase = 0; m_primed = 0; m_lr_last = 0; m_valid = 0;
      m_hold = '0; m_left = '0; m_right = '0;
    end else begin
      for (int i = SYNC+1; i > 0; i--) smp[i] = smp[i-1];
      smp[0] = {bclk, lrclk, sdata};
      b = smp[SYNC][2]; bq = smp[SYNC+1][2]; lr = smp[SYNC][1]; d = smp[SYNC][0];
      m_valid = 0;
      if (b && !bq) begin
        if (m_primed && lr != m_lr_last) begin
          w = ref_word(m_hist, cfg_long, cfg_lsb);
          if (lr) begin
            if (m_phase == 2) begin m_valid = 1; m_left = m_hold; m_right = w; end
            m_phase = 1;
          end else begin
            m_hold = w;
            if (m_phase == 1) m_phase = 2;
          end
          m_hist = int'(d);
        end else begin
          m_hist = ((m_hist << 1) | int'(d)) & 32'h3FFFF;
        end
        m_primed = 1;
        m_lr_last = lr;
      end
    end
  end

  // ---------------- expected pairs from the stimulus ----------------
  logic [17:0] q_l[$], q_r[$];
  string       q_t[$];

  always @(negedge clk) begin
    logic [17:0] el, er;
    string t;
    if (rst_n && !done) begin
      checks++;
      if (pair_valid !== m_valid || left !== m_left || right !== m_right) begin
        errors++;
        $display("FAIL R5 R6 cycle model: actual v=%0b l=%h r=%h expected v=%0b l=%h r=%h",
                 pair_valid, left, right, m_valid, m_left, m_right);
      end
      if (pair_valid === 1'b1) begin
        checks++;
        if (q_l.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected pair: actual l=%h r=%h expected none", left, right);
        end else begin
          el = q_l.pop_front(); er = q_r.pop_front(); t = q_t.pop_front();
          if (left !== el || right !== er) begin
            errors++;
            $display("FAIL %s pair: actual l=%h r=%h expected l=%h r=%h", t, left, right, el, er);
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_bit(input logic lr, input logic d);
    @(negedge clk); bclk = 1'b0; lrclk = lr; sdata = d;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_half(input logic lr, input logic [17:0] v, input int n, input bit lsb,
                           input int bits, input bit set_cfg, input bit lng);
    int pad;
    pad = bits - n;
    for (int k = 0; k < bits; k++) begin
      if (k < pad) send_bit(lr, 1'b1);
      else send_bit(lr, lsb ? v[k-pad] : v[n-1-(k-pad)]);
      if (set_cfg && k == 0) begin
        repeat (3) @(negedge clk);
        cfg_long = lng; cfg_lsb = lsb;
      end
    end
  endtask

  function automatic logic [17:0] ext(input logic [17:0] v, input bit lng);
    return lng ? v : {{2{v[15]}}, v[15:0]};
  endfunction

  task automatic send_frame(input logic [17:0] l, input logic [17:0] r, input bit lng,
                            input bit lsb, input int bits, input string tag);
    int n;
    n = lng ? 18 : 16;
    q_l.push_back(ext(l, lng)); q_r.push_back(ext(r, lng)); q_t.push_back(tag);
    send_half(1'b1, l, n, lsb, bits, 1'b1, lng);
    send_half(1'b0, r, n, lsb, bits, 1'b0, lng);
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if (pair_valid !== 1'b0 || left !== '0 || right !== '0) begin
      errors++;
      $display("FAIL %s reset state: actual v=%0b l=%h r=%h expected v=0 l=0 r=0",
               tag, pair_valid, left, right);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check_quiet("R7");
    rst_n = 1'b1;
    // R9: start inside a left half, then a lone right half; neither is published
    for (int k = 0; k < 5; k++) send_bit(1'b1, 1'b1);
    for (int k = 0; k < 18; k++) send_bit(1'b0, 1'b1);
    send_frame(18'h20001, 18'h1FFFF, 1'b1, 1'b0, 18, "R3 R2 R9");
    send_frame(18'h0A5A5, 18'h3FFFE, 1'b1, 1'b1, 24, "R8 R1");
    send_frame(18'h08000, 18'h07FFF, 1'b0, 1'b0, 16, "R4 R3");
    send_frame(18'h01234, 18'h0ABCD, 1'b0, 1'b1, 20, "R8 R4");
    send_frame(18'h00003, 18'h30000, 1'b1, 1'b0, 32, "R1");
    // R7: reset in the middle of traffic clears outputs and drops the open frame
    @(negedge clk); rst_n = 1'b0;
    q_l.delete(); q_r.delete(); q_t.delete();
    repeat (3) begin @(negedge clk); check_quiet("R7"); end
    rst_n = 1'b1;
    send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
    send_frame(18'h0FFFF, 18'h00001, 1'b0, 1'b0, 16, "R4 R2");
    send_frame(18'h00001, 18'h00002, 1'b1, 1'b0, 18, "R2 R3");
    send_bit(1'b1, 1'b0);
    repeat (10) @(negedge clk);
    checks++;
    if (q_l.size() != 0) begin
      errors++;
      $display("FAIL R5 pairs published: actual pending=%0d expected pending=0", q_l.size());
    end
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R5 watchdog expired: actual pending=%0d expected pending=0", q_l.size());
      finish_run();
    end
  end
endmodule